// File: doc/BRIEF.md
# Descriptor-Ring Audio DMA Channel

This block is a single bus-master playback channel. Software places a ring of 32 buffer descriptors in system memory and points the channel at it. The channel fetches each descriptor, reads the samples of the buffer it names and streams them one by one toward a link FIFO. It moves on through the ring until it has finished the entry that software has marked as the last valid one. Software keeps playback going by moving that marker forward while the channel runs.

Control and status are reached through a byte-wide register port. The channel raises one interrupt line for completed buffers, for completion of the last valid buffer and for FIFO errors, each with its own enable. Every descriptor also carries an underrun policy flag, which the channel passes to the link as a level.

Top module: `aud_ring_dma`

## Requirements
- R1: The ring base register (bytes 0x00 to 0x03, little-endian) ignores address bits 2:0 and always reads them as zero.
- R2: The current index (byte 0x04) and the last valid index (byte 0x05) are 5 bits wide and wrap from 31 to 0, so a run can pass the end of the ring.
- R3: Descriptor n is read at base + 8n. Word 0 is the buffer byte address. In word 1, bits 15:0 give the length in 16-bit samples, bit 31 is the completion-interrupt flag and bit 30 is the underrun policy. Sample k comes from byte address buffer + 2k, taking the upper half of the 32-bit word when address bit 1 is set. Samples leave in order on the valid/ready stream, and a length of 0 emits nothing. The remaining-count register (bytes 0x08 and 0x09) reads 0 once the descriptor is finished.
- R4: After it finishes the descriptor at the last valid index, the channel stops fetching. It then sets status (bytes 0x06 and 0x07) bit 0 (halted), bit 1 (current equals last valid) and bit 2 (last valid done).
- R5: While halted at the last valid entry, a write of a different last valid index clears bits 0 and 1, advances the current index by one and resumes. A write of the same index changes nothing.
- R6: Status bit 3 (buffer done) sets only when the finished descriptor has its completion-interrupt flag set.
- R7: Writing 1 to status bits 2, 3 or 4 clears them. Writes to bits 0 and 1 have no effect.
- R8: irq is the OR of status bit 2 AND control bit 2, status bit 4 AND control bit 3, and status bit 3 AND control bit 4. It follows the status one clock later.
- R9: Writing control (byte 0x0B) with bit 1 set clears both indices, the prefetched index (byte 0x0A), the status, the remaining count and the run bit. The base register is kept. Bit 1 reads 0 again after one cycle.
- R10: under_zero carries the underrun policy flag of the last descriptor fetched.
- R11: Control bit 0 = 0 pauses the channel after the transfer in flight. Status bit 0 reads 1 while the channel is paused, and setting the bit again continues where the channel stopped.
- R12: A pulse on fifo_err sets status bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register byte write strobe |
| reg_addr | input | 4 | Register byte address |
| reg_wdata | input | 8 | Register write byte |
| reg_rdata | output | 8 | Byte at reg_addr, one clock later |
| mem_req | output | 1 | Memory read request, held until mem_ack |
| mem_addr | output | 32 | Word-aligned read address |
| mem_ack | input | 1 | Read data valid, ends the request |
| mem_rdata | input | 32 | Read data |
| smp_valid | output | 1 | Sample available |
| smp_data | output | 16 | Sample value |
| smp_ready | input | 1 | Link FIFO accepts the sample |
| fifo_err | input | 1 | Link FIFO error pulse |
| under_zero | output | 1 | Underrun policy: 1 send zeros, 0 repeat last |
| irq | output | 1 | Channel interrupt |

## Verification
The assertions check several rules on every cycle. The base always reads back aligned. A memory request and an offered sample hold steady until they are taken. A channel halted at the last valid entry issues no reads and offers no samples. A reset write empties the indices, the count and the run bit. Sample order, the halt at the last valid index, the resume on a new index, the wrap past entry 31, pausing, write-one-to-clear and interrupt masking all depend on a sequence of programming steps, so only the bench scenarios show them. Those scenarios compare every accepted sample against a queue that the bench computes from the descriptors.

// File: rtl/aud_dma_pkg.sv
package aud_dma_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_DESC_A, ST_DESC_B, ST_DATA, ST_PUSH, ST_HOLD, ST_DONE
  } eng_state_t;

  // register byte offsets
  localparam int OFS_CIV  = 4;
  localparam int OFS_LVI  = 5;
  localparam int OFS_STS  = 6;
  localparam int OFS_STSH = 7;
  localparam int OFS_CNT  = 8;
  localparam int OFS_CNTH = 9;
  localparam int OFS_PIV  = 10;
  localparam int OFS_CTRL = 11;

  // control bits
  localparam int CB_RUN  = 0;
  localparam int CB_RST  = 1;
  localparam int CB_LVIE = 2;
  localparam int CB_IOCE = 4;

  // status bits
  localparam int SB_LVD  = 2;
  localparam int SB_BD   = 3;
  localparam int SB_FERR = 4;

  // descriptor word 1 flags
  localparam int DF_IOC  = 31;
  localparam int DF_ZERO = 30;
endpackage

// File: rtl/aud_dma_regs.sv
module aud_dma_regs
  import aud_dma_pkg::*;
#(
  parameter int AW  = 32,
  parameter int IW  = 5,
  parameter int CW  = 16,
  parameter int RAW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_we,
  input  logic [RAW-1:0] reg_addr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  input  logic [IW-1:0] civ,
  input  logic [IW-1:0] piv,
  input  logic [CW-1:0] picb,
  input  logic          ended,
  input  logic          ev_bdone,
  input  logic          ev_lvdone,
  input  logic          fifo_err,
  output logic [AW-1:0] base,
  output logic [IW-1:0] lvi,
  output logic          run,
  output logic          chan_rst,
  output logic          lvi_wr,
  output logic          irq
);
  localparam int NB = AW / 8;
  localparam logic [7:0] ALIGN_MASK = 8'hF8;

  logic [AW-1:0] base_q;
  logic [IW-1:0] lvi_q;
  logic          run_q, rr_q;
  logic [2:0]    ien_q;   // [0] last-valid, [1] fifo error, [2] buffer done
  logic          lvd_q, bd_q, ferr_q;
  logic [15:0]   sts;
  logic [15:0]   cnt16;
  logic          wr_ctrl, wr_sts;

  assign wr_ctrl  = reg_we && (reg_addr == RAW'(OFS_CTRL));
  assign wr_sts   = reg_we && (reg_addr == RAW'(OFS_STS));
  assign chan_rst = wr_ctrl && reg_wdata[CB_RST];
  assign lvi_wr   = reg_we && (reg_addr == RAW'(OFS_LVI));
  assign sts      = {11'd0, ferr_q, bd_q, lvd_q, ended, ended | ~run_q};
  assign cnt16    = 16'(picb);

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
    end else begin
      for (int b = 0; b < NB; b++) begin
        if (reg_we && reg_addr == RAW'(b))
          base_q[b*8 +: 8] <= (b == 0) ? (reg_wdata & ALIGN_MASK) : reg_wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lvi_q <= '0; run_q <= 1'b0; rr_q <= 1'b0; ien_q <= '0;
      lvd_q <= 1'b0; bd_q <= 1'b0; ferr_q <= 1'b0; irq <= 1'b0;
    end else begin
      rr_q <= chan_rst;
      irq  <= (lvd_q & ien_q[0]) | (ferr_q & ien_q[1]) | (bd_q & ien_q[2]);
      if (chan_rst) begin
        lvi_q <= '0; run_q <= 1'b0; ien_q <= reg_wdata[CB_IOCE:CB_LVIE];
        lvd_q <= 1'b0; bd_q <= 1'b0; ferr_q <= 1'b0;
      end else begin
        if (wr_ctrl) begin
          run_q <= reg_wdata[CB_RUN];
          ien_q <= reg_wdata[CB_IOCE:CB_LVIE];
        end
        if (lvi_wr) lvi_q <= reg_wdata[IW-1:0];
        if (wr_sts && reg_wdata[SB_LVD])  lvd_q  <= 1'b0;
        if (wr_sts && reg_wdata[SB_BD])   bd_q   <= 1'b0;
        if (wr_sts && reg_wdata[SB_FERR]) ferr_q <= 1'b0;
        if (ev_lvdone) lvd_q  <= 1'b1;
        if (ev_bdone)  bd_q   <= 1'b1;
        if (fifo_err)  ferr_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      reg_rdata <= '0;
      if (reg_addr < RAW'(NB))
        reg_rdata <= base_q[reg_addr[1:0]*8 +: 8];
      case (reg_addr)
        RAW'(OFS_CIV):  reg_rdata <= 8'(civ);
        RAW'(OFS_LVI):  reg_rdata <= 8'(lvi_q);
        RAW'(OFS_STS):  reg_rdata <= sts[7:0];
        RAW'(OFS_STSH): reg_rdata <= sts[15:8];
        RAW'(OFS_CNT):  reg_rdata <= cnt16[7:0];
        RAW'(OFS_CNTH): reg_rdata <= cnt16[15:8];
        RAW'(OFS_PIV):  reg_rdata <= 8'(piv);
        RAW'(OFS_CTRL): reg_rdata <= {3'd0, ien_q, rr_q, run_q};
        default: ;
      endcase
    end
  end

  assign base = base_q;
  assign lvi  = lvi_q;
  assign run  = run_q;
endmodule

// File: rtl/aud_dma_engine.sv
module aud_dma_engine
  import aud_dma_pkg::*;
#(
  parameter int AW = 32,
  parameter int IW = 5,
  parameter int CW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          chan_rst,
  input  logic          run,
  input  logic [AW-1:0] base,
  input  logic [IW-1:0] lvi,
  input  logic          lvi_wr,
  input  logic [IW-1:0] lvi_new,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata,
  output logic          smp_valid,
  output logic [DW/2-1:0] smp_data,
  input  logic          smp_ready,
  output logic          under_zero,
  output logic [IW-1:0] civ,
  output logic [IW-1:0] piv,
  output logic [CW-1:0] picb,
  output logic          ended,
  output logic          ev_bdone,
  output logic          ev_lvdone
);
  localparam int SW = DW / 2;

  eng_state_t      state;
  logic [AW-1:0]   buf_q;
  logic [SW-1:0]   smp_q;
  logic            ioc_q, zero_q;
  logic [IW-1:0]   lvi_eff;
  logic [AW-1:0]   desc_ofs;

  assign lvi_eff   = lvi_wr ? lvi_new : lvi;
  assign desc_ofs  = AW'({civ, 3'b000});
  assign mem_req   = (state == ST_DESC_A) || (state == ST_DESC_B) || (state == ST_DATA);
  assign smp_valid = (state == ST_PUSH);
  assign smp_data  = smp_q;
  assign under_zero = zero_q;
  assign ev_bdone  = (state == ST_DONE) && ioc_q;
  assign ev_lvdone = (state == ST_DONE) && (civ == lvi_eff);

  always_comb begin
    case (state)
      ST_DESC_A: mem_addr = base + desc_ofs;
      ST_DESC_B: mem_addr = base + desc_ofs + AW'(4);
      default:   mem_addr = buf_q & ~AW'(3);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || chan_rst) begin
      state <= ST_IDLE; civ <= '0; piv <= '0; picb <= '0; ended <= 1'b0;
      buf_q <= '0; smp_q <= '0; ioc_q <= 1'b0; zero_q <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (ended) begin
            if (lvi_wr && lvi_new != civ) begin
              ended <= 1'b0;
              civ   <= civ + IW'(1);
              piv   <= civ + IW'(2);
            end
          end else if (run) begin
            state <= ST_DESC_A;
          end
        end
        ST_DESC_A: if (mem_ack) begin
          buf_q <= AW'(mem_rdata);
          state <= ST_DESC_B;
        end
        ST_DESC_B: if (mem_ack) begin
          picb   <= mem_rdata[CW-1:0];
          ioc_q  <= mem_rdata[DF_IOC];
          zero_q <= mem_rdata[DF_ZERO];
          piv    <= civ + IW'(1);
          state  <= (mem_rdata[CW-1:0] == '0) ? ST_DONE : ST_DATA;
        end
        ST_DATA: if (mem_ack) begin
          smp_q <= buf_q[1] ? mem_rdata[DW-1:SW] : mem_rdata[SW-1:0];
          state <= ST_PUSH;
        end
        ST_PUSH: if (smp_ready) begin
          buf_q <= buf_q + AW'(2);
          picb  <= picb - CW'(1);
          if (picb == CW'(1)) state <= ST_DONE;
          else                state <= run ? ST_DATA : ST_HOLD;
        end
        ST_HOLD: if (run) state <= ST_DATA;
        ST_DONE: begin
          if (civ == lvi_eff) begin
            ended <= 1'b1;
            state <= ST_IDLE;
          end else begin
            civ   <= civ + IW'(1);
            state <= run ? ST_DESC_A : ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/aud_ring_dma.sv
module aud_ring_dma #(
  parameter int AW = 32,
  parameter int IW = 5,
  parameter int CW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_we,
  input  logic [3:0]    reg_addr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata,
  output logic          smp_valid,
  output logic [DW/2-1:0] smp_data,
  input  logic          smp_ready,
  input  logic          fifo_err,
  output logic          under_zero,
  output logic          irq
);
  logic [AW-1:0] base_w;
  logic [IW-1:0] lvi_w, civ_w, piv_w;
  logic [CW-1:0] picb_w;
  logic run_w, chan_rst_w, lvi_wr_w, ended_w, ev_bdone_w, ev_lvdone_w;

  aud_dma_regs #(.AW(AW), .IW(IW), .CW(CW), .RAW(4)) u_regs (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .civ(civ_w), .piv(piv_w), .picb(picb_w), .ended(ended_w),
    .ev_bdone(ev_bdone_w), .ev_lvdone(ev_lvdone_w), .fifo_err(fifo_err),
    .base(base_w), .lvi(lvi_w), .run(run_w), .chan_rst(chan_rst_w),
    .lvi_wr(lvi_wr_w), .irq(irq)
  );

  aud_dma_engine #(.AW(AW), .IW(IW), .CW(CW), .DW(DW)) u_eng (
    .clk(clk), .rst(rst), .chan_rst(chan_rst_w), .run(run_w),
    .base(base_w), .lvi(lvi_w), .lvi_wr(lvi_wr_w), .lvi_new(reg_wdata[IW-1:0]),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .smp_valid(smp_valid), .smp_data(smp_data),
    .smp_ready(smp_ready), .under_zero(under_zero), .civ(civ_w),
    .piv(piv_w), .picb(picb_w), .ended(ended_w),
    .ev_bdone(ev_bdone_w), .ev_lvdone(ev_lvdone_w)
  );
endmodule

// File: rtl/aud_ring_dma_chk.sv
module aud_ring_dma_chk #(
  parameter int AW = 32,
  parameter int IW = 5,
  parameter int CW = 16,
  parameter int SW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          reg_we,
  input logic [3:0]    reg_addr,
  input logic [7:0]    reg_wdata,
  input logic [7:0]    reg_rdata,
  input logic          mem_req,
  input logic [AW-1:0] mem_addr,
  input logic          mem_ack,
  input logic          smp_valid,
  input logic [SW-1:0] smp_data,
  input logic          smp_ready,
  input logic          ended,
  input logic          run,
  input logic [IW-1:0] civ,
  input logic [CW-1:0] picb
);
  logic rst_wr, base_wr;
  assign rst_wr  = reg_we && reg_addr == 4'd11 && reg_wdata[1];
  assign base_wr = reg_we && reg_addr < 4'd4;

  p_base_align_r1: assert property (@(posedge clk) disable iff (rst)
    ($past(reg_addr) == 4'd0) |-> (reg_rdata[2:0] == 3'b000));

  p_req_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack && !rst_wr && !base_wr) |=> (mem_req && $stable(mem_addr)));

  p_smp_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (smp_valid && !smp_ready && !rst_wr) |=> (smp_valid && $stable(smp_data)));

  p_quiet_halt_r4: assert property (@(posedge clk) disable iff (rst)
    ended |-> (!mem_req && !smp_valid));

  p_soft_reset_r9: assert property (@(posedge clk) disable iff (rst)
    rst_wr |=> (civ == '0 && picb == '0 && !run && !ended));
endmodule

bind aud_ring_dma aud_ring_dma_chk #(.AW(AW), .IW(IW), .CW(CW), .SW(DW/2)) u_chk (
  .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
  .mem_addr(mem_addr), .mem_ack(mem_ack), .smp_valid(smp_valid),
  .smp_data(smp_data), .smp_ready(smp_ready), .ended(ended_w),
  .run(run_w), .civ(civ_w), .picb(picb_w)
);

// File: tb/aud_ring_dma_bench.sv
module aud_ring_dma_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_we = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic mem_req, mem_ack;
  logic [31:0] mem_addr, mem_rdata;
  logic smp_valid, smp_ready;
  logic [15:0] smp_data;
  logic fifo_err = 1'b0;
  logic under_zero, irq;

  int vecs = 0, errs = 0, cyc = 0;
  bit ready_pat = 1'b0;
  logic [31:0] dmem [0:63];
  logic [15:0] exp_q [$];

  always #10 clk = ~clk;

  aud_ring_dma u_aud_ring_dma (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .smp_valid(smp_valid), .smp_data(smp_data), .smp_ready(smp_ready),
    .fifo_err(fifo_err), .under_zero(under_zero), .irq(irq)
  );

  function automatic logic [15:0] samp(int a);
    return 16'((a * 37) ^ 16'hA5C3);
  endfunction

  function automatic logic [31:0] mem_word(logic [31:0] w);
    if (w >= 32'h100 && w < 32'h200) return dmem[(w - 32'h100) >> 2];
    return {samp(int'(w) + 2), samp(int'(w))};
  endfunction

  // memory responder and ready pattern, updated on the rising edge
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst) begin
      mem_ack <= 1'b0; mem_rdata <= '0; smp_ready <= 1'b0;
    end else begin
      mem_ack   <= mem_req && !mem_ack;
      mem_rdata <= mem_word(mem_addr);
      smp_ready <= ready_pat ? (cyc % 3 != 1) : 1'b1;
    end
  end

  // reference stream: every accepted sample against the expected queue
  always @(negedge clk) begin
    if (!rst && smp_valid && smp_ready) begin
      vecs++;
      if (exp_q.size() == 0) begin
        errs++; $display("FAIL R3 unexpected sample act=%h exp=none", smp_data);
      end else begin
        if (smp_data !== exp_q[0]) begin
          errs++; $display("FAIL R3 sample act=%h exp=%h", smp_data, exp_q[0]);
        end
        void'(exp_q.pop_front());
      end
    end
  end

  always @(posedge clk) begin
    if (cyc == 150000) begin
      errs++;
      $display("FAIL watchdog act=%0d exp<150000 cycles", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++; $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a;
    @(negedge clk); d = reg_rdata;
  endtask

  task automatic rd16(logic [3:0] a, output logic [15:0] d);
    logic [7:0] lo, hi;
    rd(a, lo); rd(a + 4'd1, hi); d = {hi, lo};
  endtask

  task automatic set_desc(int idx, int buf_a, int len, bit ioc, bit bup);
    dmem[idx*2]     = 32'(buf_a);
    dmem[idx*2 + 1] = {ioc, bup, 14'd0, 16'(len)};
    for (int k = 0; k < len; k++) exp_q.push_back(samp(buf_a + 2*k));
  endtask

  task automatic wait_halt(string req);
    logic [15:0] s;
    for (int i = 0; i < 4000; i++) begin
      rd16(4'd6, s);
      if (s[0]) return;
    end
    chk(req, 32'(s[0]), 32'd1);
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [7:0] b;
    logic [15:0] h;
    logic [31:0] w;
    int s1;
    for (int i = 0; i < 64; i++) dmem[i] = '0;
    repeat (5) @(negedge clk);
    rst = 1'b0;

    // reset state
    rd(4'd4, b);   chk("R2 reset civ", 32'(b), 0);
    rd(4'd5, b);   chk("R2 reset lvi", 32'(b), 0);
    rd16(4'd6, h); chk("R11 reset status", 32'(h), 32'h1);
    rd16(4'd8, h); chk("R3 reset count", 32'(h), 0);
    chk("R8 reset irq", 32'(irq), 0);

    // base alignment
    wr(4'd0, 8'h05); wr(4'd1, 8'h01); wr(4'd2, 8'h00); wr(4'd3, 8'h00);
    rd(4'd0, w[7:0]); rd(4'd1, w[15:8]); rd(4'd2, w[23:16]); rd(4'd3, w[31:24]);
    chk("R1 base aligned", w, 32'h100);

    // first run: three descriptors, stalling ready
    ready_pat = 1'b1;
    set_desc(0, 32'h1000, 3, 1, 0);
    set_desc(1, 32'h2002, 2, 0, 1);
    set_desc(2, 32'h3000, 4, 1, 1);
    wr(4'd5, 8'd2);
    wr(4'd11, 8'h15);
    wait_halt("R4 halt");
    rd(4'd4, b);   chk("R4 civ at last valid", 32'(b), 2);
    rd16(4'd6, h); chk("R4 R6 status after run", 32'(h), 32'h0F);
    rd16(4'd8, h); chk("R3 count drained", 32'(h), 0);
    chk("R3 all samples out", exp_q.size(), 0);
    chk("R8 irq raised", 32'(irq), 1);
    chk("R10 policy of last desc", 32'(under_zero), 1);

    // write-one-to-clear
    wr(4'd6, 8'h08); rd16(4'd6, h); chk("R7 clear buffer done", 32'(h), 32'h07);
    wr(4'd6, 8'h03); rd16(4'd6, h); chk("R7 bits 0,1 ignore writes", 32'(h), 32'h07);
    chk("R8 irq held by last-valid", 32'(irq), 1);
    wr(4'd6, 8'h04); wait_cyc(2);
    chk("R8 irq drops", 32'(irq), 0);

    // resume with a new last valid index
    set_desc(3, 32'h4000, 1, 0, 0);
    set_desc(4, 32'h4100, 2, 0, 0);
    wr(4'd5, 8'd4); wait_cyc(2);
    wait_halt("R5 resume halt");
    rd(4'd4, b);   chk("R5 civ after resume", 32'(b), 4);
    rd16(4'd6, h); chk("R6 no buffer done without flag", 32'(h), 32'h07);
    chk("R5 resumed samples out", exp_q.size(), 0);
    chk("R10 policy zero", 32'(under_zero), 0);
    wr(4'd5, 8'd4); wait_cyc(20);
    rd(4'd4, b);   chk("R5 same index no resume", 32'(b), 4);
    rd16(4'd6, h); chk("R5 still halted", 32'(h), 32'h07);

    // wrap past entry 31
    wr(4'd6, 8'h1C);
    for (int i = 5; i < 32; i++) set_desc(i, 32'h5000 + i*16, (i == 7) ? 0 : 1, 0, 0);
    set_desc(0, 32'h6000, 1, 0, 0);
    set_desc(1, 32'h6010, 2, 0, 0);
    wr(4'd5, 8'd1); wait_cyc(2);
    wait_halt("R2 wrap halt");
    rd(4'd4, b); chk("R2 civ wrapped", 32'(b), 1);
    chk("R2 wrap samples out", exp_q.size(), 0);

    // pause before and during streaming
    ready_pat = 1'b0;
    wr(4'd6, 8'h1C);
    wr(4'd11, 8'h14);
    set_desc(2, 32'h7000, 8, 0, 0);
    set_desc(3, 32'h7100, 8, 0, 0);
    wr(4'd5, 8'd3); wait_cyc(30);
    rd16(4'd6, h); chk("R11 paused reads halted", 32'(h[0]), 1);
    chk("R11 nothing sent while paused", exp_q.size(), 16);
    wr(4'd11, 8'h15); wait_cyc(12);
    wr(4'd11, 8'h14); wait_cyc(10);
    s1 = exp_q.size(); wait_cyc(30);
    chk("R11 pause holds stream", exp_q.size(), 32'(s1));
    wr(4'd11, 8'h15); wait_cyc(2);
    wait_halt("R11 continue halt");
    chk("R11 continued samples out", exp_q.size(), 0);
    rd(4'd4, b); chk("R11 civ after continue", 32'(b), 3);

    // fifo error and masking
    wr(4'd6, 8'h1C); wait_cyc(2);
    chk("R8 irq clear", 32'(irq), 0);
    @(negedge clk); fifo_err = 1'b1; @(negedge clk); fifo_err = 1'b0;
    rd16(4'd6, h); chk("R12 fifo error bit", 32'(h[4]), 1);
    chk("R8 masked fifo error", 32'(irq), 0);
    wr(4'd11, 8'h09); wait_cyc(2);
    chk("R8 fifo error enabled", 32'(irq), 1);
    wr(4'd6, 8'h10); wait_cyc(2);
    chk("R7 R8 fifo error cleared", 32'(irq), 0);

    // channel reset bit
    wr(4'd11, 8'h02);
    rd(4'd4, b);   chk("R9 civ cleared", 32'(b), 0);
    rd(4'd5, b);   chk("R9 lvi cleared", 32'(b), 0);
    rd(4'd10, b);  chk("R9 piv cleared", 32'(b), 0);
    rd16(4'd6, h); chk("R9 status cleared", 32'(h), 32'h1);
    rd16(4'd8, h); chk("R9 count cleared", 32'(h), 0);
    rd(4'd11, b);  chk("R9 ctrl self-clears", 32'(b), 0);
    rd(4'd1, b);   chk("R9 base kept", 32'(b), 32'h01);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule